// File: doc/BRIEF.md
# CRC-Gated Receive Packet Filter

This block sits between the 64-bit receive stream of a serial link layer and the user logic. The link stream carries a valid strobe, a last-beat marker and byte-keep lanes. It cannot be stalled, and on the last beat of each packet it reports whether the packet's CRC matched. The block produces a 64-bit stream that also cannot be stalled. Each output beat carries an 8-bit side field: bits 6:0 hold the packet's payload length in 32-bit words, and bit 7 holds the CRC verdict. A packet of n words occupies ceil(n/2) beats. The first word of each beat sits in bits 31:0.

The mode is picked with `filter_mode`. When it is low, the block works as cut-through: every beat leaves one cycle after it arrives, and the length is taken from an input side field on the first beat. When it is high, the block works as store-and-forward. It collects a packet into one of two buffer banks and replays it only if the CRC passed. The length is derived from the beat count and the keep lanes of the last beat. A packet that fails the CRC leaves no trace. A packet that is too long, or that arrives while both banks still wait for replay, is dropped and marked by an `overflow` pulse.

Top module: `rxf_crc_filter`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `overflow` are low.
- R2: With `filter_mode` low, every input beat appears on the output one clock later with the same data and last marker.
- R3: With `filter_mode` low, `out_user[6:0]` equals `in_size` as sampled on the first beat of the packet, and it stays the same on every beat of that packet. Later values of `in_size` are ignored.
- R4: `out_user[7]` is 0 on every beat except the last. On the last beat in cut-through mode it equals `in_crc_ok` (1 = CRC good).
- R5: With `filter_mode` high, no beat of a packet leaves before its last beat is taken in. If no replay is in progress, the first stored beat appears two clocks after the last input beat. The beats then follow on consecutive clocks, in order.
- R6: With `filter_mode` high, a packet whose last beat has `in_crc_ok` low produces no output and no `overflow`. Every replayed last beat carries `out_user[7]` = 1.
- R7: With `filter_mode` high, `out_user[6:0]` is twice the beat count, minus one when the last beat's `in_keep` is 8'h0F. This value is present on every replayed beat.
- R8: With `filter_mode` high, a packet of more than DEPTH (63) beats is dropped. `overflow` pulses for one clock, one clock after its last beat. A packet of exactly DEPTH beats is kept.
- R9: With `filter_mode` high, two packets that arrive with no idle cycle between them are both replayed, in arrival order.
- R10: With `filter_mode` high, a packet whose first beat arrives while two accepted packets have not yet begun replay is dropped, with an `overflow` pulse after its last beat. The queued packets are still replayed.
- R11: A change of `filter_mode` made while no packet is in flight or queued applies to the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| filter_mode | input | 1 | 1 = store-and-forward with CRC gating, 0 = cut-through |
| in_valid | input | 1 | Link beat valid |
| in_data | input | 64 | Link beat data |
| in_keep | input | 8 | Byte-keep lanes of the link beat |
| in_last | input | 1 | Last beat of the packet |
| in_crc_ok | input | 1 | CRC verdict, meaningful on the last beat |
| in_size | input | 7 | Word count used in cut-through mode, sampled on the first beat |
| out_valid | output | 1 | Output beat valid, no back pressure |
| out_data | output | 64 | Output beat data |
| out_last | output | 1 | Last beat of the output packet |
| out_user | output | 8 | [6:0] word count, [7] CRC good on the last beat |
| overflow | output | 1 | One-clock pulse when a packet is dropped for lack of space |

## Verification
The hardest case to reach is the drop caused by busy banks. It needs one bank still replaying, the other bank holding an accepted packet that has not started, and a third packet arriving. The stimulus sends a ten-beat packet followed at once by three single-beat packets. The first short packet goes to the free bank. The second goes to the bank being read, behind the reader's pointer. The third finds both banks occupied and must be dropped. A 64-beat packet next to a 63-beat packet probes the depth boundary. A reference model built on queues predicts every output cycle.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    localparam int DATA_W = 64;
    localparam int KEEP_W = DATA_W / 8;
    localparam int SIZE_W = 7;
    localparam int USER_W = SIZE_W + 1;
    localparam logic [KEEP_W-1:0] KEEP_LOW_HALF = {{(KEEP_W/2){1'b0}}, {(KEEP_W/2){1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic [USER_W-1:0] user;
    } out_beat_t;

    // payload words of a stored packet: two per beat, one less if the last beat is half full
    function automatic logic [SIZE_W-1:0] word_count(input logic [SIZE_W-1:0] beats,
                                                     input logic [KEEP_W-1:0] keep);
        logic [SIZE_W-1:0] n;
        n = beats << 1;
        if (keep == KEEP_LOW_HALF) n = n - SIZE_W'(1);
        return n;
    endfunction
endpackage

// File: rtl/rxf_bypass.sv
`timescale 1ns/1ps
module rxf_bypass
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_crc_ok,
    input  logic [SIZE_W-1:0] in_size,
    output logic              o_valid,
    output out_beat_t         o_beat
);
    logic              mid;
    logic [SIZE_W-1:0] held;
    logic [SIZE_W-1:0] cur_size;

    always_comb cur_size = mid ? held : in_size;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid     <= 1'b0;
            held    <= '0;
            o_valid <= 1'b0;
            o_beat  <= '0;
        end else begin
            o_valid <= en && in_valid;
            if (en && in_valid) begin
                o_beat.data <= in_data;
                o_beat.last <= in_last;
                o_beat.user <= {in_last & in_crc_ok, cur_size};
                held        <= cur_size;
                mid         <= !in_last;
            end
        end
    end
endmodule

// File: rtl/rxf_bank_store.sv
`timescale 1ns/1ps
module rxf_bank_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 63,
    parameter int CW    = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   in_valid,
    input  logic [DATA_W-1:0]      in_data,
    input  logic [KEEP_W-1:0]      in_keep,
    input  logic                   in_last,
    input  logic                   in_crc_ok,
    input  logic                   rd_bank,
    input  logic [CW-1:0]          rd_idx,
    input  logic                   take,
    output logic [DATA_W-1:0]      rd_data,
    output logic [1:0]             full,
    output logic [1:0][CW-1:0]     bank_beats,
    output logic [1:0][SIZE_W-1:0] bank_size,
    output logic                   overflow
);
    localparam int MD = 1 << CW;

    logic          wb;
    logic [CW-1:0] wp;
    logic [CW-1:0] wp_nx;
    logic          in_pkt;
    logic          drop;
    logic          drop_now;
    logic          room;
    logic          bad;
    logic          wr_en;
    logic [DATA_W-1:0] rd_word [2];

    always_comb begin
        drop_now = in_pkt ? drop : full[wb];
        room     = wp < CW'(DEPTH);
        bad      = drop_now || !room;
        wr_en    = en && in_valid && !bad;
        wp_nx    = wp + CW'(1);
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] mem [MD];
        always_ff @(posedge clk) begin
            if (wr_en && wb == 1'(b)) mem[wp] <= in_data;
        end
        assign rd_word[b] = mem[rd_idx];
    end

    assign rd_data = rd_word[rd_bank];

    always_ff @(posedge clk) begin
        if (rst) begin
            wb         <= 1'b0;
            wp         <= '0;
            in_pkt     <= 1'b0;
            drop       <= 1'b0;
            full       <= '0;
            bank_beats <= '0;
            bank_size  <= '0;
            overflow   <= 1'b0;
        end else begin
            overflow <= 1'b0;
            if (take) full[rd_bank] <= 1'b0;
            if (en && in_valid) begin
                if (in_last) begin
                    wp       <= '0;
                    in_pkt   <= 1'b0;
                    drop     <= 1'b0;
                    overflow <= bad;
                    if (!bad && in_crc_ok) begin
                        full[wb]       <= 1'b1;
                        bank_beats[wb] <= wp_nx;
                        bank_size[wb]  <= word_count(SIZE_W'(wp_nx), in_keep);
                        wb             <= ~wb;
                    end
                end else begin
                    in_pkt <= 1'b1;
                    drop   <= bad;
                    if (!bad) wp <= wp_nx;
                end
            end
        end
    end
endmodule

// File: rtl/rxf_replay.sv
`timescale 1ns/1ps
module rxf_replay
    import rxf_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [1:0]             full,
    input  logic [1:0][CW-1:0]     bank_beats,
    input  logic [1:0][SIZE_W-1:0] bank_size,
    input  logic [DATA_W-1:0]      rd_data,
    output logic                   rd_bank,
    output logic [CW-1:0]          rd_idx,
    output logic                   take,
    output logic                   o_valid,
    output out_beat_t              o_beat
);
    logic              rb;
    logic              cb;
    logic              busy;
    logic [CW-1:0]     idx;
    logic [CW-1:0]     nb;
    logic [SIZE_W-1:0] nsz;
    logic              first_last;
    logic              cont_last;

    always_comb begin
        take       = en && !busy && full[rb];
        rd_bank    = busy ? cb : rb;
        rd_idx     = busy ? idx : '0;
        first_last = bank_beats[rb] == CW'(1);
        cont_last  = idx == nb - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rb      <= 1'b0;
            cb      <= 1'b0;
            busy    <= 1'b0;
            idx     <= '0;
            nb      <= '0;
            nsz     <= '0;
            o_valid <= 1'b0;
            o_beat  <= '0;
        end else begin
            o_valid <= 1'b0;
            if (take) begin
                o_valid     <= 1'b1;
                o_beat.data <= rd_data;
                o_beat.last <= first_last;
                o_beat.user <= {first_last, bank_size[rb]};
                nb          <= bank_beats[rb];
                nsz         <= bank_size[rb];
                cb          <= rb;
                rb          <= ~rb;
                busy        <= !first_last;
                idx         <= CW'(1);
            end else if (busy) begin
                o_valid     <= 1'b1;
                o_beat.data <= rd_data;
                o_beat.last <= cont_last;
                o_beat.user <= {cont_last, nsz};
                idx         <= idx + CW'(1);
                if (cont_last) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxf_crc_filter.sv
`timescale 1ns/1ps
module rxf_crc_filter
    import rxf_pkg::*;
#(
    parameter int DEPTH = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              filter_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [KEEP_W-1:0] in_keep,
    input  logic              in_last,
    input  logic              in_crc_ok,
    input  logic [SIZE_W-1:0] in_size,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [USER_W-1:0] out_user,
    output logic              overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    logic                   bp_valid;
    out_beat_t              bp_beat;
    logic                   rp_valid;
    out_beat_t              rp_beat;
    logic                   rd_bank;
    logic [CW-1:0]          rd_idx;
    logic                   take;
    logic [DATA_W-1:0]      rd_data;
    logic [1:0]             full;
    logic [1:0][CW-1:0]     bank_beats;
    logic [1:0][SIZE_W-1:0] bank_size;
    out_beat_t              sel;

    rxf_bypass u_bypass (
        .clk(clk), .rst(rst), .en(!filter_mode),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_crc_ok(in_crc_ok), .in_size(in_size),
        .o_valid(bp_valid), .o_beat(bp_beat)
    );

    rxf_bank_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst(rst), .en(filter_mode),
        .in_valid(in_valid), .in_data(in_data), .in_keep(in_keep),
        .in_last(in_last), .in_crc_ok(in_crc_ok),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .take(take),
        .rd_data(rd_data), .full(full), .bank_beats(bank_beats),
        .bank_size(bank_size), .overflow(overflow)
    );

    rxf_replay #(.CW(CW)) u_replay (
        .clk(clk), .rst(rst), .en(filter_mode),
        .full(full), .bank_beats(bank_beats), .bank_size(bank_size),
        .rd_data(rd_data), .rd_bank(rd_bank), .rd_idx(rd_idx), .take(take),
        .o_valid(rp_valid), .o_beat(rp_beat)
    );

    always_comb begin
        out_valid = filter_mode ? rp_valid : bp_valid;
        sel       = filter_mode ? rp_beat : bp_beat;
        out_data  = sel.data;
        out_last  = sel.last;
        out_user  = sel.user;
    end
endmodule

// File: rtl/rxf_crc_filter_chk.sv
`timescale 1ns/1ps
module rxf_crc_filter_chk
    import rxf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              filter_mode,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic [USER_W-1:0] out_user,
    input logic              overflow
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && !overflow)); // R1

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!filter_mode && in_valid) |=>
        (filter_mode || (out_valid && out_data == $past(in_data) && out_last == $past(in_last)))); // R2

    AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(out_last)) |->
        (out_user[SIZE_W-1:0] == $past(out_user[SIZE_W-1:0]))); // R3

    AST_FLAG_LAST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> !out_user[USER_W-1]); // R4

    AST_FILTER_PASS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (filter_mode && out_valid && out_last) |-> out_user[USER_W-1]); // R6

    AST_NO_OVERFLOW_MIDPKT: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(in_valid && in_last && filter_mode)); // R8
endmodule

bind rxf_crc_filter rxf_crc_filter_chk u_chk (.*);

// File: tb/tb_rxf_crc_filter.sv
`timescale 1ns/1ps
module tb_rxf_crc_filter;
    import rxf_pkg::*;

    localparam int DEPTH = 63;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        filter_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_keep = '0;
    logic        in_last = 1'b0;
    logic        in_crc_ok = 1'b0;
    logic [6:0]  in_size = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_last;
    logic [7:0]  out_user;
    logic        overflow;

    rxf_crc_filter #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .filter_mode(filter_mode),
        .in_valid(in_valid), .in_data(in_data), .in_keep(in_keep),
        .in_last(in_last), .in_crc_ok(in_crc_ok), .in_size(in_size),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_user(out_user), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    int    word_ctr = 0;

    // reference model state
    bit          e_valid, e_last, e_ovf;
    logic [63:0] e_data;
    logic [7:0]  e_user;
    bit          bp_mid;
    logic [6:0]  bp_held;
    bit          w_inpkt, w_drop;
    int          w_cnt;
    logic [63:0] w_beats[$];
    logic [63:0] pend_data[$];
    int          pend_len[$];
    int          pend_size[$];
    int          cur_left = 0;
    int          cur_size = 0;

    task automatic model_step();
        int npend;
        logic [6:0] sz;
        npend   = pend_len.size();
        e_valid = 1'b0; e_last = 1'b0; e_ovf = 1'b0; e_data = '0; e_user = '0;
        if (!filter_mode) begin
            if (in_valid) begin
                sz      = bp_mid ? bp_held : in_size;
                e_valid = 1'b1;
                e_data  = in_data;
                e_last  = in_last;
                e_user  = {in_last & in_crc_ok, sz};
                bp_held = sz;
                bp_mid  = !in_last;
            end
        end else begin
            if (cur_left == 0 && pend_len.size() > 0) begin
                cur_left = pend_len.pop_front();
                cur_size = pend_size.pop_front();
            end
            if (cur_left > 0) begin
                e_valid  = 1'b1;
                e_data   = pend_data.pop_front();
                cur_left = cur_left - 1;
                e_last   = (cur_left == 0);
                e_user   = {e_last, 7'(cur_size)};
            end
            if (in_valid) begin
                if (!w_inpkt) begin
                    w_drop = (npend == 2);
                    w_beats.delete();
                    w_cnt = 0;
                end
                if (w_cnt == DEPTH) w_drop = 1'b1;
                if (!w_drop) begin
                    w_beats.push_back(in_data);
                    w_cnt++;
                end
                if (in_last) begin
                    e_ovf = w_drop;
                    if (!w_drop && in_crc_ok) begin
                        foreach (w_beats[i]) pend_data.push_back(w_beats[i]);
                        pend_len.push_back(w_cnt);
                        pend_size.push_back(2 * w_cnt - ((in_keep == 8'h0F) ? 1 : 0));
                    end
                    w_inpkt = 1'b0;
                    w_drop  = 1'b0;
                end else begin
                    w_inpkt = 1'b1;
                end
            end
        end
    endtask

    task automatic compare();
        bit bad;
        checks++;
        bad = (out_valid !== e_valid) || (overflow !== e_ovf);
        if (e_valid && (out_data !== e_data || out_last !== e_last || out_user !== e_user)) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s t=%0t actual valid=%0b data=%h last=%0b user=%h ovf=%0b expected valid=%0b data=%h last=%0b user=%h ovf=%0b",
                     tag, $time, out_valid, out_data, out_last, out_user, overflow,
                     e_valid, e_data, e_last, e_user, e_ovf);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; in_last = 1'b0; in_crc_ok = 1'b0; in_keep = '0;
        for (int i = 0; i < n; i++) tick();
    endtask

    // sends nb beats back to back; gap_at inserts one idle cycle after that beat
    task automatic send_pkt(input int nb, input bit ok, input logic [7:0] last_keep,
                            input int sz, input int gap_at);
        for (int i = 0; i < nb; i++) begin
            in_valid  = 1'b1;
            in_data   = {32'(word_ctr + 1), 32'(word_ctr)};
            word_ctr  = word_ctr + 2;
            in_last   = (i == nb - 1);
            in_keep   = in_last ? last_keep : 8'hFF;
            in_crc_ok = in_last ? ok : !ok;
            in_size   = (i == 0) ? 7'(sz) : 7'(i * 13 + 3);
            tick();
            if (i == gap_at && i != nb - 1) begin
                in_valid = 1'b0;
                tick();
            end
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        checks++;
        if (out_valid !== 1'b0 || overflow !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual valid=%0b ovf=%0b expected valid=0 ovf=0", out_valid, overflow);
        end
        rst = 1'b0;
        tick(); // R1 first cycle after reset is quiet

        filter_mode = 1'b0;
        tag = "R2"; send_pkt(3, 1'b1, 8'hFF, 5, 0); idle(2);
        tag = "R3"; send_pkt(2, 1'b1, 8'hFF, 4, -1); send_pkt(3, 1'b1, 8'h0F, 6, 1); idle(2);
        tag = "R4"; send_pkt(2, 1'b0, 8'hFF, 3, -1); send_pkt(1, 1'b1, 8'h0F, 1, -1); idle(3);

        tag = "R11"; filter_mode = 1'b1; idle(2);
        tag = "R5"; send_pkt(4, 1'b1, 8'hFF, 0, 1); idle(8);
        tag = "R7"; send_pkt(3, 1'b1, 8'h0F, 0, -1); idle(6);
        send_pkt(1, 1'b1, 8'h0F, 0, -1); idle(4);
        tag = "R6"; send_pkt(5, 1'b0, 8'hFF, 0, -1); idle(3);
        send_pkt(2, 1'b1, 8'hFF, 0, -1); idle(5);
        tag = "R9"; send_pkt(3, 1'b1, 8'hFF, 0, -1); send_pkt(2, 1'b1, 8'h0F, 0, -1); idle(8);
        tag = "R8"; send_pkt(DEPTH + 1, 1'b1, 8'hFF, 0, -1); idle(3);
        send_pkt(DEPTH, 1'b1, 8'h0F, 0, -1); idle(DEPTH + 6);
        tag = "R10";
        send_pkt(10, 1'b1, 8'hFF, 0, -1);
        send_pkt(1, 1'b1, 8'hFF, 0, -1);
        send_pkt(1, 1'b1, 8'h0F, 0, -1);
        send_pkt(1, 1'b1, 8'hFF, 0, -1);
        idle(20);

        tag = "R11"; filter_mode = 1'b0; idle(2);
        send_pkt(2, 1'b1, 8'hFF, 3, -1); idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule